// File: doc/BRIEF.md
# Tamper Event Detector

This block watches a single tamper input from an enclosure switch or a similar sensor. It reports a tamper event in one of two ways. The first treats the input as a closed loop that must stay closed. The second reacts to a transition of the input in a direction that software selects. The raw pin is first passed through a two-flop synchronizer and then through a debounce filter whose length software can program. Only the filtered level is evaluated.

When an event is recognised, a sticky status flag is set. In the same clock edge, the time-of-day and date words presented by the real-time clock are copied into capture registers. The flag drives an output that cuts the standby supply of the SRAM, so that its contents are invalidated. Flag, cut-off and captured timestamp all stay frozen on the first event until software clears the flag. The power switch and the clock counters live outside this block.

Software reaches the block through a simple single-cycle write port and a combinational read port. Through these it sets the enable, the mode, the edge direction and the debounce length, and it reads status and the captured timestamp.

Top module: `tamper_guard`

## Requirements
- R1: After reset, CONTROL (address 0) reads 0, FILTER (address 1) reads 4, STATUS (address 2) reads 0, both capture registers read 0 and `sram_cut` is low.
- R2: The pin passes through two synchronizer flops. The filtered level takes the synchronized value only after the two have differed for FILTER+1 consecutive clocks. A pulse seen for FILTER clocks or fewer is ignored. STATUS bit 1 reads the filtered level.
- R3: With CONTROL bit 1 = 0 (closed-loop mode), a filtered level of 1 (loop open) is an event, for as long as it lasts.
- R4: With CONTROL bit 1 = 1 (edge mode), a change of the filtered level is an event. CONTROL bit 2 = 0 selects a 0-to-1 change and bit 2 = 1 selects a 1-to-0 change. A change in the other direction is not an event.
- R5: While CONTROL bit 0 (enable) is 0, no event is recognised. Setting enable while the level is steady produces no edge event.
- R6: An event sets STATUS bit 0. In the same edge it loads TIME (address 3) and DATE (address 4) with the values present on `rtc_time` and `rtc_date`.
- R7: While STATUS bit 0 is set, further events do not change TIME or DATE.
- R8: `sram_cut` equals STATUS bit 0 and stays high until software writes STATUS with bit 0 = 1. Writing bit 0 = 0 has no effect.
- R9: If an event is present in the cycle of a clearing write, the event wins. The flag stays set and TIME and DATE take the current timestamp.
- R10: Writes to CONTROL and FILTER read back unchanged in their defined bits (CONTROL bits 2:0, FILTER bits 7:0). Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tamper_pin | input | 1 | Asynchronous tamper input |
| rtc_time | input | TIME_W | Current time of day from the real-time clock |
| rtc_date | input | DATE_W | Current date from the real-time clock |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| sram_cut | output | 1 | High to remove SRAM standby power |

## Verification
The bench places a pulse exactly one clock shorter than the debounce window and then one that just fills it. A filter off by one would latch the short glitch or drop the valid pulse. It enables the detector with the pin already high in edge mode, and clears the flag while an open loop persists. A design that compares against a stale level would report a false edge on enable. A design that gives the clear priority would lose the persisting event or keep an old timestamp. Random trials over mode, direction, enable and start and end levels catch a wrong edge direction or an overwritten first capture.

// File: rtl/tg_pkg.sv
package tg_pkg;

    typedef enum logic {
        MODE_LOOP = 1'b0,
        MODE_EDGE = 1'b1
    } tg_mode_e;

    typedef struct packed {
        logic     fall;
        tg_mode_e mode;
        logic     en;
    } tg_ctrl_t;

    localparam int unsigned A_CONTROL = 0;
    localparam int unsigned A_FILTER  = 1;
    localparam int unsigned A_STATUS  = 2;
    localparam int unsigned A_TIME    = 3;
    localparam int unsigned A_DATE    = 4;

    localparam int unsigned FILTER_RESET = 4;

    function automatic logic tg_hit(tg_ctrl_t c, logic prev, logic cur);
        logic r;
        if (!c.en)
            r = 1'b0;
        else if (c.mode == MODE_LOOP)
            r = cur;
        else if (c.fall)
            r = prev & ~cur;
        else
            r = ~prev & cur;
        return r;
    endfunction

endpackage

// File: rtl/tg_filter.sv
module tg_filter #(
    parameter int unsigned DEB_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_i,
    input  logic [DEB_W-1:0] len_i,
    output logic             level_o
);
    logic [1:0]       sync_q;
    logic [DEB_W-1:0] cnt_q;
    logic             level_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[0], pin_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            level_q <= 1'b0;
        end else if (sync_q[1] != level_q) begin
            if (cnt_q >= len_i) begin
                level_q <= sync_q[1];
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign level_o = level_q;

    // R2: a level change always adopts the synchronized value
    p_filter_follow_r2: assert property (@(posedge clk) disable iff (rst)
        (level_q != $past(level_q)) |-> (level_q == $past(sync_q[1])));

    // R2: no change unless the window was filled
    p_filter_window_r2: assert property (@(posedge clk) disable iff (rst)
        (level_q != $past(level_q)) |-> ($past(cnt_q) >= $past(len_i)));
endmodule

// File: rtl/tg_detect.sv
module tg_detect
    import tg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  tg_ctrl_t ctrl_i,
    input  logic     level_i,
    output logic     evt_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level_i;
    end

    assign evt_o = tg_hit(ctrl_i, prev_q, level_i);

    // R4: an edge-mode event needs a real change of the level
    p_edge_change_r4: assert property (@(posedge clk) disable iff (rst)
        (evt_o && ctrl_i.mode == MODE_EDGE) |-> (level_i != $past(level_i)));
endmodule

// File: rtl/tg_capture.sv
module tg_capture #(
    parameter int unsigned TIME_W = 32,
    parameter int unsigned DATE_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_i,
    input  logic              clr_i,
    input  logic [TIME_W-1:0] time_i,
    input  logic [DATE_W-1:0] date_i,
    output logic              flag_o,
    output logic [TIME_W-1:0] time_o,
    output logic [DATE_W-1:0] date_o
);
    logic              flag_q;
    logic [TIME_W-1:0] time_q;
    logic [DATE_W-1:0] date_q;
    logic              take;

    assign take = evt_i && (!flag_q || clr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            time_q <= '0;
            date_q <= '0;
        end else begin
            flag_q <= (flag_q && !clr_i) || evt_i;
            if (take) begin
                time_q <= time_i;
                date_q <= date_i;
            end
        end
    end

    assign flag_o = flag_q;
    assign time_o = time_q;
    assign date_o = date_q;

    // R6: a new flag carries the timestamp of its edge
    p_capture_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> (time_q == $past(time_i) && date_q == $past(date_i)));

    // R6: the flag rises only on an event
    p_rise_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(evt_i));

    // R7: a held flag freezes the capture
    p_hold_first_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(flag_q) && !$past(clr_i)) |-> ($stable(time_q) && $stable(date_q)));

    // R8: the flag only falls on a clearing write
    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/tamper_guard.sv
module tamper_guard
    import tg_pkg::*;
#(
    parameter int unsigned TIME_W = 32,
    parameter int unsigned DATE_W = 32,
    parameter int unsigned DEB_W  = 8,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tamper_pin,
    input  logic [TIME_W-1:0] rtc_time,
    input  logic [DATE_W-1:0] rtc_date,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sram_cut
);
    localparam int unsigned CTRL_W = $bits(tg_ctrl_t);

    tg_ctrl_t          ctrl_q;
    logic [DEB_W-1:0]  len_q;
    logic              level;
    logic              evt;
    logic              clr;
    logic              flag;
    logic [TIME_W-1:0] cap_time;
    logic [DATE_W-1:0] cap_date;
    logic              unused_wbits;

    assign unused_wbits = ^reg_wdata[DATA_W-1:DEB_W];

    assign clr = reg_wr && (reg_addr == ADDR_W'(A_STATUS)) && reg_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            len_q  <= DEB_W'(FILTER_RESET);
        end else if (reg_wr) begin
            if (reg_addr == ADDR_W'(A_CONTROL)) ctrl_q <= tg_ctrl_t'(reg_wdata[CTRL_W-1:0]);
            if (reg_addr == ADDR_W'(A_FILTER))  len_q  <= reg_wdata[DEB_W-1:0];
        end
    end

    tg_filter #(.DEB_W(DEB_W)) u_filter (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (tamper_pin),
        .len_i  (len_q),
        .level_o(level)
    );

    tg_detect u_detect (
        .clk    (clk),
        .rst    (rst),
        .ctrl_i (ctrl_q),
        .level_i(level),
        .evt_o  (evt)
    );

    tg_capture #(.TIME_W(TIME_W), .DATE_W(DATE_W)) u_capture (
        .clk   (clk),
        .rst   (rst),
        .evt_i (evt),
        .clr_i (clr),
        .time_i(rtc_time),
        .date_i(rtc_date),
        .flag_o(flag),
        .time_o(cap_time),
        .date_o(cap_date)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(A_CONTROL): reg_rdata = DATA_W'(ctrl_q);
            ADDR_W'(A_FILTER):  reg_rdata = DATA_W'(len_q);
            ADDR_W'(A_STATUS):  reg_rdata = DATA_W'({level, flag});
            ADDR_W'(A_TIME):    reg_rdata = DATA_W'(cap_time);
            ADDR_W'(A_DATE):    reg_rdata = DATA_W'(cap_date);
            default:            reg_rdata = '0;
        endcase
    end

    assign sram_cut = flag;

    // R5: a disabled detector never raises the flag
    p_disarmed_r5: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.en && !flag) |=> !sram_cut);

    // R9: an event during a clearing write keeps the flag up
    p_event_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (clr && evt) |=> sram_cut);
endmodule

// File: tb/tamper_guard_tb.sv
module tamper_guard_tb;
    localparam int TW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tamper_pin = 1'b0;
    logic [TW-1:0] rtc_time = '0;
    logic [DW-1:0] rtc_date = '0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          sram_cut;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tamper_guard u_dut (
        .clk(clk), .rst(rst), .tamper_pin(tamper_pin),
        .rtc_time(rtc_time), .rtc_date(rtc_date),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sram_cut(sram_cut)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 3'(a);
        #1 d = reg_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit exp_event(bit en, bit edge_m, bit fall, bit s, bit e);
        if (!en) return 1'b0;
        if (!edge_m) return s | e;
        if (fall) return s & ~e;
        return ~s & e;
    endfunction

    function automatic logic [31:0] ctrl_word(bit en, bit edge_m, bit fall);
        return {29'd0, fall, edge_m, en};
    endfunction

    initial begin
        logic [31:0] v;
        logic [31:0] cap_t, cap_d;
        void'($urandom(32'd1234));

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(0, v); check("R1 control", v, 0);
        rd(1, v); check("R1 filter", v, 4);
        rd(2, v); check("R1 status", v, 0);
        rd(3, v); check("R1 time", v, 0);
        rd(4, v); check("R1 date", v, 0);
        check("R1 sram_cut", 32'(sram_cut), 0);
        rd(6, v); check("R10 unmapped", v, 0);

        // R10 readback
        wr(1, 32'hFFFF_FF05); rd(1, v); check("R10 filter readback", v, 32'h05);
        wr(0, 32'hFFFF_FFF6); rd(0, v); check("R10 control readback", v, 32'h6);

        // R2 debounce boundary: filter 5, edge rising enabled
        wr(0, ctrl_word(1, 1, 0));
        rtc_time = 32'h0000_1111; rtc_date = 32'h2222_0000;
        @(negedge clk); tamper_pin = 1'b1;
        idle(5); tamper_pin = 1'b0;
        idle(15);
        rd(2, v); check("R2 short pulse ignored", v, 0);
        tamper_pin = 1'b1;
        idle(6); tamper_pin = 1'b0;
        idle(4);
        rd(2, v); check("R2 full pulse flag", 32'(v[0]), 1);
        rd(3, v); check("R6 time captured", v, 32'h0000_1111);
        rd(4, v); check("R6 date captured", v, 32'h2222_0000);
        check("R8 sram_cut follows flag", 32'(sram_cut), 1);
        idle(10);

        // R7 second event does not overwrite
        rtc_time = 32'h0000_3333; rtc_date = 32'h4444_0000;
        tamper_pin = 1'b1; idle(15);
        rd(3, v); check("R7 time held", v, 32'h0000_1111);
        rd(4, v); check("R7 date held", v, 32'h2222_0000);
        rd(2, v); check("R2 level reads high", 32'(v[1]), 1);

        // R8 write 0 ignored, write 1 clears
        wr(2, 32'h0); rd(2, v); check("R8 write zero no effect", 32'(v[0]), 1);
        check("R8 sram_cut still high", 32'(sram_cut), 1);
        wr(2, 32'h1); rd(2, v); check("R8 cleared", 32'(v[0]), 0);
        check("R8 sram_cut low", 32'(sram_cut), 0);

        // R4 wrong direction: rising mode, pin falls
        tamper_pin = 1'b0; idle(15);
        rd(2, v); check("R4 wrong direction", 32'(v[0]), 0);

        // R5 enable with level already high in edge mode
        wr(0, ctrl_word(0, 1, 0));
        tamper_pin = 1'b1; idle(15);
        rd(2, v); check("R5 disabled edge", 32'(v[0]), 0);
        wr(0, ctrl_word(1, 1, 0)); idle(5);
        rd(2, v); check("R5 enable on steady level", 32'(v[0]), 0);

        // R3 and R9: loop mode, open loop persists through clear
        rtc_time = 32'h0000_5555; rtc_date = 32'h6666_0000;
        wr(0, ctrl_word(1, 0, 0)); idle(2);
        rd(2, v); check("R3 open loop event", 32'(v[0]), 1);
        rd(3, v); check("R3 time", v, 32'h0000_5555);
        rtc_time = 32'h0000_7777; rtc_date = 32'h8888_0000;
        wr(2, 32'h1);
        rd(2, v); check("R9 event wins flag", 32'(v[0]), 1);
        rd(3, v); check("R9 fresh time", v, 32'h0000_7777);
        rd(4, v); check("R9 fresh date", v, 32'h8888_0000);
        cap_t = 32'h0000_7777; cap_d = 32'h8888_0000;

        // random trials
        wr(1, 32'd2);
        for (int t = 0; t < 60; t++) begin
            bit en, em, fl, s, e, ev;
            logic [31:0] ts, ds;
            en = 1'($urandom_range(0, 3) != 0);
            em = 1'($urandom);
            fl = 1'($urandom);
            s  = 1'($urandom);
            e  = 1'($urandom);
            ts = $urandom; ds = $urandom;
            wr(0, 32'h0);
            tamper_pin = s; idle(12);
            wr(2, 32'h1);
            rtc_time = ts; rtc_date = ds;
            wr(0, ctrl_word(en, em, fl)); idle(3);
            tamper_pin = e; idle(12);
            ev = exp_event(en, em, fl, s, e);
            if (ev) begin cap_t = ts; cap_d = ds; end
            rd(2, v);
            check(em ? "R4 random flag" : "R3 random flag", 32'(v[0]), 32'(ev));
            check("R5 random sram_cut", 32'(sram_cut), 32'(ev));
            rd(3, v); check("R6 random time", v, cap_t);
            rd(4, v); check("R6 random date", v, cap_d);
        end

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule